// File: doc/BRIEF.md
# ATA Task-File Command Decoder

This block is the device-side register model of an ATA disk interface. A host drives a small register bus with an offset, a read strobe, a write strobe and 32-bit data. The block holds the task-file registers and an alternate-status/device-control location. It runs each command code written to the command location and keeps the BSY, DRDY, DRQ and error status bits. It streams a 128-word identify block through one data port that advances on each read. DMA commands go to an external engine through a start pulse and a done strobe. A level interrupt request is raised at command completion when the host has not masked it.

The identify words come from outside the block. The block presents a word index and takes back the 32-bit word at that index, so the table can be a ROM, fuses or logic elsewhere. Each set-features command hands its feature and subcommand bytes to the rest of the device as a one-cycle strobe with two data bytes.

Top module: `ata_taskfile_dec`

## Requirements
- R1: After reset the status byte (offset 7) and the alternate status (offset 8) read 0x40 (DRDY only), the error byte (offset 1) reads 0, and `irq` and `dma_start` are low.
- R2: Writes to offsets 2 to 6 are read back from the same offset in the low byte, with the upper bits zero. A write to offset 1 loads the feature byte and does not change what offset 1 reads (the error byte). Offsets 9 to 15 read 0, and writes to them change nothing.
- R3: A write to offset 7 while BSY (status bit 7) is clear is accepted. On the next cycle BSY reads 1 and DRDY (bit 6) reads 0. A write to offset 7 while BSY is set is ignored.
- R4: Code 0x90 sets the sector count to 1 and clears offsets 3 to 6. From then on the alternate status reads the status byte ORed with 0x0D.
- R5: Code 0xEC sets DRQ (status bit 3) and restarts the word index at 0. Each read of offset 0 while DRQ is set returns identify word n and then advances n. The read of word 127 clears DRQ. A read of offset 0 while DRQ is clear returns 0 and does not advance.
- R6: Code 0xEF pulses `feat_strobe` for one cycle, with `feat_code` equal to the feature byte and `feat_sub` equal to the sector count. It leaves DRDY set and DRQ clear.
- R7: Codes 0xC8 and 0xCA pulse `dma_start` for one cycle, one cycle after the command write. `dma_dir` is 1 for 0xC8 and 0 for 0xCA. BSY stays set until `dma_done` is sampled high, and clears on the next cycle.
- R8: Any other code completes after one busy cycle and sets ABRT (error byte bit 2, status bit 0). The next accepted command clears ABRT.
- R9: When a command completes while nIEN (bit 1 of the byte written to offset 8) is 0, `irq` rises and nIEN becomes 1. When it completes with nIEN at 1, `irq` does not change.
- R10: A read of offset 7 drops `irq` unless a command completes in the same cycle. A read of offset 8 leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, side effects at the clock edge |
| reg_wdata | input | 32 | Write data, low byte used |
| reg_rdata | output | 32 | Read data for the current offset (combinational) |
| ident_addr | output | 7 | Identify word index |
| ident_word | input | 32 | Identify word at `ident_addr` |
| dma_start | output | 1 | One-cycle DMA request |
| dma_dir | output | 1 | 1: device to host, 0: host to device |
| dma_done | input | 1 | DMA engine finished |
| feat_code | output | 8 | Recorded feature byte |
| feat_sub | output | 8 | Recorded subcommand byte |
| feat_strobe | output | 1 | One-cycle pulse when a feature pair is recorded |
| irq | output | 1 | Interrupt request level |

## Verification
The bench reads the status byte in the single busy cycle right after a command write. A decoder that finished commands in zero cycles, or left DRDY set, fails that read. A command written in the middle of a DMA transfer must leave no trace: a design that accepted it would show DRQ or clear BSY early. The bench walks the identify block past its last word and then restarts it partway through, which exposes an off-by-one end count and a counter that does not reset. Interrupts are checked with nIEN both clear and set, and with status and alternate-status reads, so a broken mask or the wrong clearing register leaves `irq` at the wrong level.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  // register offsets; the decode depends on them
  localparam int unsigned OFS_DATA    = 0;
  localparam int unsigned OFS_ERRFEAT = 1;
  localparam int unsigned OFS_SECCNT  = 2;
  localparam int unsigned OFS_LBA_LO  = 3;
  localparam int unsigned OFS_LBA_MID = 4;
  localparam int unsigned OFS_LBA_HI  = 5;
  localparam int unsigned OFS_DEVSEL  = 6;
  localparam int unsigned OFS_STATCMD = 7;
  localparam int unsigned OFS_ALTCTL  = 8;

  localparam logic [7:0] OP_DIAG    = 8'h90;
  localparam logic [7:0] OP_IDENT   = 8'hEC;
  localparam logic [7:0] OP_SETFEAT = 8'hEF;
  localparam logic [7:0] OP_DMA_IN  = 8'hC8;
  localparam logic [7:0] OP_DMA_OUT = 8'hCA;

  localparam logic [7:0] DIAG_ALT_OR = 8'h0D;
  localparam int unsigned MASK_BIT   = 1;

  typedef enum logic [2:0] {
    K_DIAG, K_IDENT, K_FEAT, K_DMA, K_BAD
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_EXEC, SQ_DMA
  } seq_state_e;

  function automatic cmd_kind_e classify(input logic [7:0] code);
    case (code)
      OP_DIAG:               return K_DIAG;
      OP_IDENT:              return K_IDENT;
      OP_SETFEAT:            return K_FEAT;
      OP_DMA_IN, OP_DMA_OUT: return K_DMA;
      default:               return K_BAD;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic busy, input logic ready,
                                             input logic xfer, input logic fault);
    return {busy, ready, 2'b00, xfer, 2'b00, fault};
  endfunction

  function automatic logic [7:0] error_byte(input logic aborted);
    return {5'b00000, aborted, 2'b00};
  endfunction

endpackage

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic       dma_done,
  output logic       cmd_accept,
  output logic       cmd_done,
  output logic       bsy,
  output logic       drdy,
  output logic       abrt,
  output logic       run_diag,
  output logic       run_ident,
  output logic       run_feat,
  output logic       dma_start,
  output logic       dma_dir
);

  seq_state_e state_q;
  logic [7:0] code_q;
  cmd_kind_e  kind;

  assign kind       = classify(code_q);
  assign bsy        = (state_q != SQ_IDLE);
  assign cmd_accept = cmd_wr && !bsy;

  assign run_diag   = (state_q == SQ_EXEC) && (kind == K_DIAG);
  assign run_ident  = (state_q == SQ_EXEC) && (kind == K_IDENT);
  assign run_feat   = (state_q == SQ_EXEC) && (kind == K_FEAT);
  assign dma_start  = (state_q == SQ_EXEC) && (kind == K_DMA);
  assign dma_dir    = (code_q == OP_DMA_IN);
  assign cmd_done   = ((state_q == SQ_EXEC) && (kind != K_DMA)) ||
                      ((state_q == SQ_DMA) && dma_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      code_q  <= 8'h00;
    end else begin
      case (state_q)
        SQ_IDLE: if (cmd_accept) begin
          code_q  <= cmd_code;
          state_q <= SQ_EXEC;
        end
        SQ_EXEC: state_q <= (kind == K_DMA) ? SQ_DMA : SQ_IDLE;
        SQ_DMA:  if (dma_done) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drdy <= 1'b1;
      abrt <= 1'b0;
    end else begin
      if (cmd_accept) begin
        drdy <= 1'b0;
        abrt <= 1'b0;
      end
      if (run_feat) drdy <= 1'b1;
      if ((state_q == SQ_EXEC) && (kind == K_BAD)) abrt <= 1'b1;
    end
  end

endmodule

// File: rtl/ata_ident_port.sv
module ata_ident_port #(
  parameter int unsigned WORDS = 128,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drop,
  input  logic          arm,
  input  logic          data_rd,
  output logic          drq,
  output logic          adv,
  output logic [AW-1:0] word_idx
);

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  assign adv = data_rd && drq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq      <= 1'b0;
      word_idx <= '0;
    end else if (arm) begin
      drq      <= 1'b1;
      word_idx <= '0;
    end else if (drop) begin
      drq      <= 1'b0;
    end else if (adv) begin
      word_idx <= word_idx + 1'b1;
      if (word_idx == LAST) drq <= 1'b0;
    end
  end

endmodule

// File: rtl/ata_irq_gate.sv
module ata_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_mask,
  input  logic done,
  input  logic ack,
  output logic irq,
  output logic nien
);

  logic fire;
  assign fire = done && !nien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nien <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (fire)        nien <= 1'b1;
      else if (ctl_wr) nien <= ctl_mask;
      if (fire)        irq <= 1'b1;
      else if (ack)    irq <= 1'b0;
    end
  end

endmodule

// File: rtl/ata_taskfile_dec.sv
module ata_taskfile_dec
  import ata_tf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ID_WORDS = 128,
  localparam int unsigned IDX_W   = $clog2(ID_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [IDX_W-1:0]  ident_addr,
  input  logic [DATA_W-1:0] ident_word,
  output logic              dma_start,
  output logic              dma_dir,
  input  logic              dma_done,
  output logic [7:0]        feat_code,
  output logic [7:0]        feat_sub,
  output logic              feat_strobe,
  output logic              irq
);

  logic [7:0] wbyte;
  logic       unused_wdata_hi;
  assign wbyte           = reg_wdata[7:0];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:8];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // named internal events
  logic cmd_wr, ctl_wr, stat_rd, data_rd;
  logic cmd_accept, cmd_done, bsy, drdy, abrt, drq, nien, id_adv;
  logic run_diag, run_ident, run_feat;

  assign cmd_wr  = reg_wr && hit(reg_addr, OFS_STATCMD);
  assign ctl_wr  = reg_wr && hit(reg_addr, OFS_ALTCTL);
  assign stat_rd = reg_rd && hit(reg_addr, OFS_STATCMD);
  assign data_rd = reg_rd && hit(reg_addr, OFS_DATA);

  ata_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_code   (wbyte),
    .dma_done   (dma_done),
    .cmd_accept (cmd_accept),
    .cmd_done   (cmd_done),
    .bsy        (bsy),
    .drdy       (drdy),
    .abrt       (abrt),
    .run_diag   (run_diag),
    .run_ident  (run_ident),
    .run_feat   (run_feat),
    .dma_start  (dma_start),
    .dma_dir    (dma_dir)
  );

  ata_ident_port #(.WORDS(ID_WORDS)) u_ident (
    .clk      (clk),
    .rst_n    (rst_n),
    .drop     (cmd_accept),
    .arm      (run_ident),
    .data_rd  (data_rd),
    .drq      (drq),
    .adv      (id_adv),
    .word_idx (ident_addr)
  );

  ata_irq_gate u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_mask (wbyte[MASK_BIT]),
    .done     (cmd_done),
    .ack      (stat_rd),
    .irq      (irq),
    .nien     (nien)
  );

  // task-file storage
  logic [7:0] feat_r, seccnt_r, lba_lo_r, lba_mid_r, lba_hi_r, dev_r, alt_or_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_r    <= 8'h00;
      seccnt_r  <= 8'h00;
      lba_lo_r  <= 8'h00;
      lba_mid_r <= 8'h00;
      lba_hi_r  <= 8'h00;
      dev_r     <= 8'h00;
      alt_or_r  <= 8'h00;
    end else begin
      if (reg_wr && hit(reg_addr, OFS_ERRFEAT)) feat_r    <= wbyte;
      if (reg_wr && hit(reg_addr, OFS_SECCNT))  seccnt_r  <= wbyte;
      if (reg_wr && hit(reg_addr, OFS_LBA_LO))  lba_lo_r  <= wbyte;
      if (reg_wr && hit(reg_addr, OFS_LBA_MID)) lba_mid_r <= wbyte;
      if (reg_wr && hit(reg_addr, OFS_LBA_HI))  lba_hi_r  <= wbyte;
      if (reg_wr && hit(reg_addr, OFS_DEVSEL))  dev_r     <= wbyte;
      if (run_diag) begin
        seccnt_r  <= 8'h01;
        lba_lo_r  <= 8'h00;
        lba_mid_r <= 8'h00;
        lba_hi_r  <= 8'h00;
        dev_r     <= 8'h00;
        alt_or_r  <= alt_or_r | DIAG_ALT_OR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_code   <= 8'h00;
      feat_sub    <= 8'h00;
      feat_strobe <= 1'b0;
    end else begin
      feat_strobe <= run_feat;
      if (run_feat) begin
        feat_code <= feat_r;
        feat_sub  <= seccnt_r;
      end
    end
  end

  // read mux
  logic [7:0] stat_b;
  assign stat_b = status_byte(bsy, drdy, drq, abrt);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_DATA):    reg_rdata = drq ? ident_word : '0;
      ADDR_W'(OFS_ERRFEAT): reg_rdata = DATA_W'(error_byte(abrt));
      ADDR_W'(OFS_SECCNT):  reg_rdata = DATA_W'(seccnt_r);
      ADDR_W'(OFS_LBA_LO):  reg_rdata = DATA_W'(lba_lo_r);
      ADDR_W'(OFS_LBA_MID): reg_rdata = DATA_W'(lba_mid_r);
      ADDR_W'(OFS_LBA_HI):  reg_rdata = DATA_W'(lba_hi_r);
      ADDR_W'(OFS_DEVSEL):  reg_rdata = DATA_W'(dev_r);
      ADDR_W'(OFS_STATCMD): reg_rdata = DATA_W'(stat_b);
      ADDR_W'(OFS_ALTCTL):  reg_rdata = DATA_W'(stat_b | alt_or_r);
      default:              reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_accept,
  input logic cmd_done,
  input logic stat_rd,
  input logic bsy,
  input logic drq,
  input logic nien,
  input logic irq,
  input logic dma_start
);

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> bsy); // R3

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !bsy); // R7

  AST_DMA_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start); // R7

  AST_DRQ_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> !bsy); // R5

  AST_IRQ_RISE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> nien); // R9

  AST_MASKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && nien && !stat_rd) |=> (irq == $past(irq))); // R9

  AST_STATUS_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_done) |=> !irq); // R10

endmodule

bind ata_taskfile_dec ata_tf_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_accept (cmd_accept),
  .cmd_done   (cmd_done),
  .stat_rd    (stat_rd),
  .bsy        (bsy),
  .drq        (drq),
  .nien       (nien),
  .irq        (irq),
  .dma_start  (dma_start)
);

// File: tb/ata_taskfile_dec_tb.sv
`timescale 1ns/1ps
module ata_taskfile_dec_tb;

  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  ident_addr;
  logic [31:0] ident_word;
  logic        dma_start, dma_dir;
  logic        dma_done = 1'b0;
  logic [7:0]  feat_code, feat_sub;
  logic        feat_strobe, irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #(HALF) clk = ~clk;

  function automatic logic [31:0] id_model(input int i);
    return {8'(i), 8'(~i), 8'hC3, 8'(i * 3)};
  endfunction

  assign ident_word = id_model(int'(ident_addr));

  ata_taskfile_dec u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ident_addr(ident_addr), .ident_word(ident_word),
    .dma_start(dma_start), .dma_dir(dma_dir), .dma_done(dma_done),
    .feat_code(feat_code), .feat_sub(feat_sub), .feat_strobe(feat_strobe),
    .irq(irq)
  );

  // scoreboard queues
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares read data just after the strobe is driven
  initial forever begin
    @(negedge clk);
    #0.5;
    if (reg_rd) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: unexpected read actual 0x%08h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata, e, t);
      end
    end
  end

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = {24'hA5A5A5, d}; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk({31'b0, irq}, 0, "R1 irq");
    chk({31'b0, dma_start}, 0, "R1 dma_start");
    rd(4'd7, 32'h40, "R1 status");
    rd(4'd8, 32'h40, "R1 alt status");
    rd(4'd1, 32'h00, "R1 error");

    // R2 register file and unmapped offsets
    wr(4'd1, 8'h5A);
    wr(4'd2, 8'h11); wr(4'd3, 8'h22); wr(4'd4, 8'h33);
    wr(4'd5, 8'h44); wr(4'd6, 8'h55);
    rd(4'd1, 32'h00, "R2 feature not visible");
    rd(4'd2, 32'h11, "R2 seccnt");
    rd(4'd3, 32'h22, "R2 lba lo");
    rd(4'd4, 32'h33, "R2 lba mid");
    rd(4'd5, 32'h44, "R2 lba hi");
    rd(4'd6, 32'h55, "R2 device");
    wr(4'd9, 8'hFF); wr(4'd15, 8'hFF);
    rd(4'd9, 32'h0, "R2 unmapped 9");
    rd(4'd15, 32'h0, "R2 unmapped 15");
    rd(4'd2, 32'h11, "R2 seccnt after unmapped write");
    rd(4'd7, 32'h40, "R2 status after unmapped write");

    // R6 set features; R3 busy cycle; R10 ack
    wr(4'd1, 8'h03); wr(4'd2, 8'h45);
    wr(4'd7, 8'hEF);
    rd(4'd7, 32'h80, "R3 busy cycle after command");
    chk({31'b0, feat_strobe}, 1, "R6 strobe");
    chk({24'b0, feat_code}, 32'h03, "R6 feature code");
    chk({24'b0, feat_sub}, 32'h45, "R6 subcommand");
    chk({31'b0, irq}, 1, "R9 irq raised");
    rd(4'd8, 32'h40, "R6 alt status drdy");
    chk({31'b0, feat_strobe}, 0, "R6 strobe one cycle");
    chk({31'b0, irq}, 1, "R10 alt read keeps irq");
    rd(4'd7, 32'h40, "R6 status");
    chk({31'b0, irq}, 0, "R10 status read clears irq");

    // R9 masked (nIEN set by the last raise); R4 diagnostics
    wr(4'd7, 8'h90);
    idle(2);
    chk({31'b0, irq}, 0, "R9 masked completion");
    rd(4'd2, 32'h01, "R4 seccnt");
    rd(4'd3, 32'h00, "R4 lba lo");
    rd(4'd4, 32'h00, "R4 lba mid");
    rd(4'd5, 32'h00, "R4 lba hi");
    rd(4'd6, 32'h00, "R4 device");
    rd(4'd7, 32'h00, "R4 status");
    rd(4'd8, 32'h0D, "R4 alt status");

    // R8 unknown code with interrupts enabled
    wr(4'd8, 8'h00);
    wr(4'd7, 8'h55);
    idle(1);
    chk({31'b0, irq}, 1, "R9 unmasked completion");
    rd(4'd1, 32'h04, "R8 error abrt");
    rd(4'd7, 32'h01, "R8 status err");
    chk({31'b0, irq}, 0, "R10 cleared");

    // R7 read DMA, R3 command during busy ignored
    wr(4'd8, 8'h00);
    wr(4'd7, 8'hC8);
    chk({31'b0, dma_start}, 1, "R7 start pulse");
    chk({31'b0, dma_dir}, 1, "R7 dir for C8");
    wr(4'd7, 8'hEC);
    chk({31'b0, dma_start}, 0, "R7 start one cycle");
    idle(3);
    rd(4'd7, 32'h80, "R3 busy during dma, abrt cleared");
    rd(4'd1, 32'h00, "R8 abrt cleared by next command");
    chk({31'b0, irq}, 0, "R7 no irq before done");
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk({31'b0, irq}, 1, "R9 irq at dma done");
    rd(4'd7, 32'h00, "R3 ignored command left no drq");

    // R7 write DMA
    wr(4'd8, 8'h00);
    wr(4'd7, 8'hCA);
    chk({31'b0, dma_start}, 1, "R7 start CA");
    chk({31'b0, dma_dir}, 0, "R7 dir for CA");
    idle(2);
    rd(4'd7, 32'h80, "R7 still busy");
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    rd(4'd7, 32'h00, "R7 busy cleared");

    // R5 identify
    wr(4'd7, 8'hEC);
    idle(1);
    rd(4'd7, 32'h08, "R5 drq set");
    for (int i = 0; i < 128; i++) rd(4'd0, id_model(i), "R5 identify word");
    rd(4'd7, 32'h00, "R5 drq cleared after last word");
    rd(4'd0, 32'h0, "R5 data read with drq clear");
    wr(4'd7, 8'hEC);
    idle(1);
    for (int i = 0; i < 3; i++) rd(4'd0, id_model(i), "R5 second pass");
    wr(4'd7, 8'hEC);
    idle(1);
    rd(4'd0, id_model(0), "R5 restart index");
    rd(4'd0, id_model(1), "R5 restart next");

    idle(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule